// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block sits on the host side of a digital step attenuator that is programmed over a three-wire serial link (data, clock, latch enable). A client offers a requested attenuation in quarter-dB units on a valid/ready handshake. The block turns the request into an eight-bit attenuation word, shifts it out least significant bit first with a slow serial clock, then pulses latch enable so the attenuator takes the new state. It keeps the mode select line high (serial mode) and the parallel control lines low throughout.

All serial timing (clock high and low times, data setup and hold, latch setup and pulse width) is counted in system clock cycles. Each count is worked out at elaboration from a clock-period parameter and a nanosecond limit, rounded up, and never less than one cycle. After each word is latched, the block refuses new requests for a holdoff interval, so successive attenuation changes are at least 40 us apart. A request offered during holdoff waits with ready low; it is never lost.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is held and straight after it, serial data, serial clock, latch enable and done are low, mode select is high, the parallel lines are all zero, and ready is high.
- R2: A request is taken in a cycle with valid and ready both high; ready is low in the next cycle and stays low until the word is latched and holdoff has elapsed; while ready is high no serial clock edge or latch pulse occurs; every request taken is sent exactly once.
- R3: The transmitted word is the request value (quarter-dB units, so 50 means 12.5 dB) for values 0 to 127; any value of 128 or more is sent as 127; the last bit shifted (bit 7) is always 0.
- R4: Each word is sent as exactly 8 rising serial clock edges, bit 0 first and bit 7 last, with data stable while the clock is high and held for at least the setup count before each rising edge.
- R5: Every serial clock high phase, and every low phase between two rising edges of one word, lasts at least the half-period count (5 cycles at the defaults, giving at most 10 MHz).
- R6: Latch enable is low at every rising serial clock edge, rises at least the latch setup count after the last rising edge, and stays high for at least the latch pulse count (3 cycles, 30 ns, at the defaults) before it falls.
- R7: Done is a one-cycle pulse in the cycle latch enable returns low; at the defaults it comes 85 cycles after the accepting cycle.
- R8: Mode select stays high and all parallel control lines stay low at all times.
- R9: After the done pulse, ready stays low for exactly the holdoff count (4000 cycles, 40 us, at the defaults) and then rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_atten | input | 8 | Requested attenuation in quarter-dB units |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_clk | output | 1 | Serial clock to the attenuator |
| ser_le | output | 1 | Latch enable to the attenuator |
| mode_ser | output | 1 | Mode select, high for serial mode |
| par_ctl | output | 7 | Parallel control lines, held low |
| done | output | 1 | Pulse when a word has been latched |

## Verification
All outputs are registered, so a request seen with valid and ready high at a falling edge starts shifting by the next falling edge, and done is expected exactly 85 falling edges after the accepting one at the defaults, with ready due back exactly 4001 falling edges after done. The bench samples every output at the falling clock edge, one half cycle after the registers move, and measures high, low, setup and latch runs in whole cycles against the rounded-up counts. It decodes the word from the serial lines on each rising serial clock edge and compares it, at the latch rise, with the saturated request captured at acceptance.

// File: rtl/asm_pkg.sv
package asm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_LESU,
        ST_LEHI,
        ST_DONE
    } asm_state_e;

    // cycles needed to cover ns at a clock period of period_ps, rounded up, at least 1
    function automatic int ns_to_cyc(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asm_word_fmt.sv
module asm_word_fmt #(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] req_val,
    output logic [WORD_W-1:0] word
);
    localparam logic [WORD_W-1:0] TOP_CODE = {1'b0, {(WORD_W-1){1'b1}}};

    // R3: top bit reserved low, larger requests saturate
    always_comb begin
        if (req_val[WORD_W-1]) word = TOP_CODE;
        else                   word = req_val;
    end
endmodule

// File: rtl/asm_holdoff.sv
module asm_holdoff #(
    parameter int HOLD = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

    logic [HW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = HOLD_V;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
    import asm_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int WORD_W        = 8,
    parameter int SCLK_HALF_NS  = 50,
    parameter int SDI_SETUP_NS  = 10,
    parameter int SDI_HOLD_NS   = 10,
    parameter int LE_SETUP_NS   = 10,
    parameter int LE_PULSE_NS   = 30,
    parameter int HOLDOFF_NS    = 40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_atten,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_le,
    output logic              mode_ser,
    output logic [WORD_W-2:0] par_ctl,
    output logic              done
);
    localparam int T_LO  = imax(ns_to_cyc(SCLK_HALF_NS, CLK_PERIOD_PS),
                                ns_to_cyc(SDI_SETUP_NS, CLK_PERIOD_PS));
    localparam int T_HI  = imax(ns_to_cyc(SCLK_HALF_NS, CLK_PERIOD_PS),
                                ns_to_cyc(SDI_HOLD_NS, CLK_PERIOD_PS));
    localparam int T_LES = ns_to_cyc(LE_SETUP_NS, CLK_PERIOD_PS);
    localparam int T_LEP = ns_to_cyc(LE_PULSE_NS, CLK_PERIOD_PS);
    localparam int T_HLD = ns_to_cyc(HOLDOFF_NS, CLK_PERIOD_PS);
    localparam int CW    = $clog2(imax(imax(T_LO, T_HI), imax(T_LES, T_LEP)) + 1);
    localparam int IW    = $clog2(WORD_W);

    localparam logic [CW-1:0] LO_RL  = CW'(T_LO - 1);
    localparam logic [CW-1:0] HI_RL  = CW'(T_HI - 1);
    localparam logic [CW-1:0] LES_RL = CW'(T_LES - 1);
    localparam logic [CW-1:0] LEP_RL = CW'(T_LEP - 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_W - 1);

    typedef struct packed {
        asm_state_e        state;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [WORD_W-1:0] word;
        logic              sclk;
        logic              sdi;
        logic              le;
        logic              done;
    } ctrl_t;

    ctrl_t             ctl_d, ctl_q;
    logic [WORD_W-1:0] fmt_word;
    logic              hold_busy;
    logic              take;

    asm_word_fmt #(.WORD_W(WORD_W)) u_fmt (
        .req_val (req_atten),
        .word    (fmt_word)
    );

    asm_holdoff #(.HOLD(T_HLD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ctl_q.done),
        .busy  (hold_busy)
    );

    assign req_ready = (ctl_q.state == ST_IDLE) && !hold_busy;
    assign take      = req_valid && req_ready;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (take) begin
                    ctl_d.state = ST_LOW;
                    ctl_d.cnt   = LO_RL;
                    ctl_d.idx   = '0;
                    ctl_d.word  = fmt_word;
                    ctl_d.sdi   = fmt_word[0];
                    ctl_d.sclk  = 1'b0;
                end
            end
            ST_LOW: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.state = ST_HIGH;
                    ctl_d.cnt   = HI_RL;
                    ctl_d.sclk  = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_HIGH: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.sclk = 1'b0;
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.state = ST_LESU;
                        ctl_d.cnt   = LES_RL;
                        ctl_d.sdi   = 1'b0;
                    end else begin
                        ctl_d.state = ST_LOW;
                        ctl_d.cnt   = LO_RL;
                        ctl_d.idx   = ctl_q.idx + 1'b1;
                        ctl_d.sdi   = ctl_q.word[ctl_q.idx + 1'b1];
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_LESU: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.state = ST_LEHI;
                    ctl_d.cnt   = LEP_RL;
                    ctl_d.le    = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_LEHI: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.state = ST_DONE;
                    ctl_d.le    = 1'b0;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, cnt: '0, idx: '0, word: '0,
                       sclk: 1'b0, sdi: 1'b0, le: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ser_data = ctl_q.sdi;
    assign ser_clk  = ctl_q.sclk;
    assign ser_le   = ctl_q.le;
    assign done     = ctl_q.done;
    // R8: serial mode only, parallel lines parked low
    assign mode_ser = 1'b1;
    assign par_ctl  = '0;

endmodule

// File: rtl/asm_checker.sv
module asm_checker #(
    parameter int WORD_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ser_data,
    input logic ser_clk,
    input logic ser_le,
    input logic done
);
    localparam int RW = $clog2(WORD_W + 1);

    logic [RW-1:0] rise_cnt;
    logic          sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt  <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= ser_clk;
            if (ser_le)                     rise_cnt <= '0;
            else if (ser_clk && !sclk_prev) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ser_clk) && rise_cnt == RW'(WORD_W - 1)) |-> !ser_data);

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    a_r6_le_low_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> !ser_le);

    a_r7_done_on_le_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(ser_le));

    a_r9_ready_low_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !req_ready);

    a_r2_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ser_clk && !ser_le));
endmodule

bind atten_serial_master asm_checker #(.WORD_W(WORD_W)) u_asm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .ser_le    (ser_le),
    .done      (done)
);

// File: tb/atten_serial_master_bench.sv
module atten_serial_master_bench;
    localparam int PER_PS = 10000;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + PER_PS - 1) / PER_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int HALF_C  = cyc(50);
    localparam int SETUP_C = cyc(10);
    localparam int LESU_C  = cyc(10);
    localparam int LEPW_C  = cyc(30);
    localparam int HOLD_C  = cyc(40000);
    localparam int LAT_C   = 8 * (2 * HALF_C) + LESU_C + LEPW_C + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_atten = 8'd0;
    logic       req_ready, ser_data, ser_clk, ser_le, mode_ser, done;
    logic [6:0] par_ctl;

    always #5 clk = ~clk;

    atten_serial_master u_atten_serial_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_atten(req_atten), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_le(ser_le), .mode_ser(mode_ser), .par_ctl(par_ctl), .done(done)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int v);
        return (v > 127) ? 127 : v;
    endfunction

    // monitor state
    int   n = 0;
    bit   p_sclk = 0, p_le = 0, p_sdi = 0;
    int   hi_run = 0, lo_run = 0, sdi_run = 0, le_run = 0;
    int   rises = 0, last_rise_n = 0;
    logic [7:0] shreg = 8'd0;
    int   exp_q = 0;
    int   acc_n = 0, done_n = 0;
    bit   wait_ready = 0;
    int   accepts = 0, latches = 0;

    always @(negedge clk) begin
        n++;
        if (rst_n) begin
            chk(mode_ser == 1'b1 && par_ctl == 7'd0, "R8 mode/parallel", int'(par_ctl), 0);
            if (ser_data != p_sdi) sdi_run = 0; else sdi_run++;
            if (ser_clk && !p_sclk) begin
                chk(!ser_le, "R6 le low at clock rise", int'(ser_le), 0);
                chk(sdi_run >= SETUP_C, "R4 data setup", sdi_run, SETUP_C);
                if (rises > 0) chk(lo_run >= HALF_C, "R5 low phase", lo_run, HALF_C);
                shreg = {ser_data, shreg[7:1]};
                rises++;
                last_rise_n = n;
                hi_run = 1;
            end else if (ser_clk) begin
                hi_run++;
                chk(ser_data == p_sdi, "R4 data hold while high", int'(ser_data), int'(p_sdi));
            end
            if (!ser_clk && p_sclk) begin
                chk(hi_run >= HALF_C, "R5 high phase", hi_run, HALF_C);
                lo_run = 1;
            end else if (!ser_clk) lo_run++;
            if (ser_le && !p_le) begin
                chk(rises == 8, "R4 rising edges per word", rises, 8);
                chk(int'(shreg) == exp_q, "R3 latched word", int'(shreg), exp_q);
                chk(shreg[7] == 1'b0, "R3 bit7 zero", int'(shreg[7]), 0);
                chk(n - last_rise_n >= LESU_C, "R6 latch setup", n - last_rise_n, LESU_C);
                le_run = 1;
            end else if (ser_le) le_run++;
            if (!ser_le && p_le) begin
                chk(le_run >= LEPW_C, "R6 latch pulse", le_run, LEPW_C);
                chk(done == 1'b1, "R7 done with le fall", int'(done), 1);
            end
            if (done) begin
                chk(n == acc_n + LAT_C, "R7 done latency", n - acc_n, LAT_C);
                latches++;
                rises = 0;
                done_n = n;
                wait_ready = 1;
            end
            if (req_ready) begin
                chk(!ser_clk && !ser_le, "R2 quiet while ready", int'(ser_clk), 0);
                if (wait_ready) begin
                    chk(n == done_n + HOLD_C + 1, "R9 holdoff length", n - done_n - 1, HOLD_C);
                    wait_ready = 0;
                end
            end
            if (req_valid && req_ready) begin
                exp_q = exp_word(int'(req_atten));
                acc_n = n;
                accepts++;
            end
        end
        p_sclk = ser_clk;
        p_le   = ser_le;
        p_sdi  = ser_data;
    end

    int sent = 0;

    task automatic send(input logic [7:0] v);
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_atten = v;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        sent++;
        // R2: ready falls the cycle after acceptance
        @(negedge clk);
        chk(!req_ready, "R2 ready drops after take", int'(req_ready), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!ser_data && !ser_clk && !ser_le && !done, "R1 serial lines in reset",
            int'({ser_data, ser_clk, ser_le, done}), 0);
        chk(mode_ser && par_ctl == 7'd0, "R1 mode/parallel in reset", int'(par_ctl), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(!ser_clk && !ser_le, "R2 idle quiet", int'(ser_clk), 0);
        // directed corners (R3): 12.5 dB, zero, max legal, saturation
        send(8'd50);
        send(8'd0);     // requested while holdoff runs: stalled, not dropped (R2, R9)
        send(8'd127);
        send(8'd128);
        send(8'd255);
        send(8'd1);
        // random mix
        for (int i = 0; i < 12; i++) begin
            int gap;
            gap = int'($urandom % 30);
            repeat (gap) @(posedge clk);
            send(8'($urandom));
        end
        repeat (LAT_C + 10) @(negedge clk);
        chk(accepts == sent, "R2 every request taken once", accepts, sent);
        chk(latches == sent, "R2 every request latched", latches, sent);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule